// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read side of a burst-capable memory port. A host takes chip enable and latch enable low together and presents a start address. At that valid clock edge the sequencer captures the address and a configuration word. It waits a programmable number of cycles, then presents one memory word per data cycle and steps the address itself. The word is read through a combinational array port: the block drives `mem_addr`, and `mem_rdata` returns the word for that address within the same cycle.

The configuration word sets the following: the burst size (4, 8 or 16 words, or unbounded), whether addressing wraps inside the aligned block, the initial latency, which clock edge is the active one, whether each word is held for one or two cycles, and the polarity of the wait pin. A suspend input freezes the burst at any point and releases the data bus; when suspend is released the burst carries on from the word it had reached. Raising chip enable abandons the burst.

Top module: `burst_rd_seq`

## Requirements
- R1: At a valid edge with `ce_n` and `le_n` both low, the address on `addr_in` is captured. Latency field `cfg[6:4]` with value L in 2..7 (values 0 and 1 act as 7) puts the first word on `dout` L valid edges later. Between capture and that edge, `dout_oe` is low and wait is active.
- R2: `cfg[8]`=0 makes the rising clock edge the valid edge, and `cfg[8]`=1 makes the falling edge the valid edge.
- R3: Burst size field `cfg[2:0]`: 0 gives 4 words, 1 gives 8 words, 2 gives 16 words, and any other value gives an unbounded burst. Each word shown equals the array word at the current address.
- R4: With `cfg[3]`=1 and a bounded size of N words, the address after A is (A with its low log2(N) bits replaced by the low bits of A+1), so it stays in the aligned N-word block. With `cfg[3]`=0, or in an unbounded burst, the next address is A+1.
- R5: In an unbounded burst, exactly one extra wait cycle appears before the first word after the start whose address is a multiple of 16. During that cycle `dout_oe` stays high. Later 16-word crossings add no wait cycle.
- R6: `cfg[7]`=0 shows each word for one valid cycle, and `cfg[7]`=1 shows it for two.
- R7: `cfg[9]`=1 makes `wait_out` active-high, and `cfg[9]`=0 makes it active-low. Wait is inactive whenever the sequencer is idle.
- R8: After the last word of a bounded burst, wait is active, `dout_oe` stays high and `dout` keeps the last word. This lasts until chip enable rises or a new capture happens.
- R9: A valid edge that sees `susp` high during a burst freezes every counter and the address. After that edge, `dout_oe` is low, wait is active and `dout` is unchanged. The burst resumes on the second edge after `susp` falls and delivers the same word sequence it would have delivered without the suspend.
- R10: A valid edge that sees `ce_n` high returns the sequencer to idle, with `dout_oe` low and wait inactive.
- R11: After reset, `dout_oe` is low, wait is inactive and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the valid edge is chosen by `cfg[8]` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| le_n | input | 1 | Latch enable, active low |
| susp | input | 1 | Suspend request, active high |
| addr_in | input | AW | Burst start address |
| cfg | input | 10 | Configuration word |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | DW | Array read data for `mem_addr` |
| dout | output | DW | Output word |
| dout_oe | output | 1 | Output drive enable; low stands for high impedance |
| wait_out | output | 1 | Wait indication, polarity from `cfg[9]` |

## Verification
The hardest case to reach is a suspend that lands on an awkward cycle: inside the latency count, on the second cycle of a held word, on the extra wait cycle of an unbounded burst, or after a bounded burst has ended. Only a word sequence compared after the burst can show that no word was skipped or repeated. The bench therefore drives suspend on random cycles of many bursts with random sizes, wrap modes, holds and start addresses. It collapses the visible words into a sequence and compares that with the address walk computed from the requirements. Separate cycle-exact bursts pin down the latency, the extra wait cycle and the end of burst.

// File: rtl/brs_pkg.sv
package brs_pkg;
    localparam int CFG_W    = 10;
    localparam int F_BL_LO  = 0;
    localparam int F_WRAP   = 3;
    localparam int F_LAT_LO = 4;
    localparam int F_HOLD   = 7;
    localparam int F_EDGE   = 8;
    localparam int F_POL    = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAT,
        S_DATA,
        S_GAP,
        S_END
    } st_e;

    // log2 of the bounded block size selected by the size field
    function automatic logic [2:0] blk_log2(input logic [2:0] sel);
        case (sel)
            3'd0:    return 3'd2;
            3'd1:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_unbounded(input logic [2:0] sel);
        return sel > 3'd2;
    endfunction

    function automatic logic [4:0] blk_words(input logic [2:0] lg);
        return 5'd1 << lg;
    endfunction
endpackage

// File: rtl/brs_lat_map.sv
module brs_lat_map (
    input  logic [2:0] code,
    output logic [2:0] cycles
);
    // codes below two fall back to the longest latency
    assign cycles = (code < 3'd2) ? 3'd7 : code;
endmodule

// File: rtl/brs_addr_step.sv
module brs_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    blg,
    input  logic          wrap,
    input  logic          unbounded,
    output logic [AW-1:0] nxt,
    output logic          on_b16
);
    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        mask = AW'((32'd1 << blg) - 32'd1);
        inc  = cur + AW'(1);
        if (wrap && !unbounded) begin
            nxt = (cur & ~mask) | (inc & mask);
        end else begin
            nxt = inc;
        end
        on_b16 = (nxt[3:0] == 4'd0);
    end
endmodule

// File: rtl/brs_wait_drv.sv
module brs_wait_drv (
    input  logic busy,
    input  logic act_high,
    output logic pin
);
    assign pin = act_high ? busy : ~busy;
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             le_n,
    input  logic             susp,
    input  logic [AW-1:0]    addr_in,
    input  logic [CFG_W-1:0] cfg,
    output logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    dout,
    output logic             dout_oe,
    output logic             wait_out
);
    typedef struct packed {
        st_e           st;
        logic [2:0]    cnt;
        logic [AW-1:0] addr;
        logic [4:0]    nw;
        logic          ph;
        logic          crossed;
        logic          frz;
        logic [DW-1:0] dout;
        logic          unb;
        logic [2:0]    blg;
        logic          wrap;
        logic          hold2;
    } state_t;

    state_t r_q, r_d;

    logic          vclk;
    logic [2:0]    lat_cyc;
    logic [AW-1:0] nxt_addr;
    logic          nxt_b16;
    logic          wait_act;

    // the valid edge is the rising edge of this derived clock
    assign vclk = clk ^ cfg[F_EDGE];

    brs_lat_map u_lat (
        .code   (cfg[F_LAT_LO +: 3]),
        .cycles (lat_cyc)
    );

    brs_addr_step #(.AW(AW)) u_step (
        .cur       (r_q.addr),
        .blg       (r_q.blg),
        .wrap      (r_q.wrap),
        .unbounded (r_q.unb),
        .nxt       (nxt_addr),
        .on_b16    (nxt_b16)
    );

    always_comb begin
        r_d = r_q;
        if (ce_n) begin
            r_d.st  = S_IDLE;
            r_d.frz = 1'b0;
            r_d.ph  = 1'b0;
        end else if (!le_n) begin
            r_d.st      = S_LAT;
            r_d.cnt     = lat_cyc;
            r_d.addr    = addr_in;
            r_d.nw      = 5'd0;
            r_d.ph      = 1'b0;
            r_d.crossed = 1'b0;
            r_d.frz     = 1'b0;
            r_d.unb     = is_unbounded(cfg[F_BL_LO +: 3]);
            r_d.blg     = blk_log2(cfg[F_BL_LO +: 3]);
            r_d.wrap    = cfg[F_WRAP];
            r_d.hold2   = cfg[F_HOLD];
        end else if (r_q.st == S_IDLE) begin
            r_d.frz = 1'b0;
        end else if (susp) begin
            r_d.frz = 1'b1;
        end else if (r_q.frz) begin
            r_d.frz = 1'b0;
        end else begin
            case (r_q.st)
                S_LAT: begin
                    if (r_q.cnt == 3'd1) begin
                        r_d.dout = mem_rdata;
                        r_d.st   = S_DATA;
                        r_d.nw   = 5'd1;
                        r_d.ph   = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt - 3'd1;
                    end
                end
                S_DATA: begin
                    if (r_q.hold2 && !r_q.ph) begin
                        r_d.ph = 1'b1;
                    end else if (!r_q.unb && (r_q.nw == blk_words(r_q.blg))) begin
                        r_d.st = S_END;
                    end else begin
                        r_d.addr = nxt_addr;
                        r_d.ph   = 1'b0;
                        if (r_q.unb && !r_q.crossed && nxt_b16) begin
                            r_d.crossed = 1'b1;
                            r_d.st      = S_GAP;
                        end else begin
                            r_d.dout = mem_rdata;
                            if (!r_q.unb) begin
                                r_d.nw = r_q.nw + 5'd1;
                            end
                        end
                    end
                end
                S_GAP: begin
                    r_d.dout = mem_rdata;
                    r_d.st   = S_DATA;
                    r_d.ph   = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge vclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, cnt: 3'd0, addr: '0, nw: 5'd0, ph: 1'b0,
                     crossed: 1'b0, frz: 1'b0, dout: '0, unb: 1'b0,
                     blg: 3'd2, wrap: 1'b0, hold2: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // in a data cycle the array is addressed with the word to load next
    assign mem_addr = (r_q.st == S_DATA) ? nxt_addr : r_q.addr;

    assign wait_act = (r_q.st == S_LAT) || (r_q.st == S_GAP) ||
                      (r_q.st == S_END) || (r_q.frz && (r_q.st != S_IDLE));
    assign dout_oe  = ((r_q.st == S_DATA) || (r_q.st == S_GAP) ||
                       (r_q.st == S_END)) && !r_q.frz;
    assign dout     = r_q.dout;

    brs_wait_drv u_wait (
        .busy     (wait_act),
        .act_high (cfg[F_POL]),
        .pin      (wait_out)
    );
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
    parameter int DW = 16
) (
    input logic          vclk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          le_n,
    input logic          susp,
    input logic          dout_oe,
    input logic          wait_act,
    input logic [DW-1:0] dout
);
    // R10
    abort_idle_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        ce_n |=> (!dout_oe && !wait_act));

    // R1
    capture_lat_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (!ce_n && !le_n) |=> (!dout_oe && wait_act));

    // R9
    susp_hide_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (!ce_n && le_n && susp && (dout_oe || wait_act)) |=> (!dout_oe && wait_act));

    // R9
    susp_keep_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (!ce_n && le_n && susp && (dout_oe || wait_act)) |=> $stable(dout));

    // R1
    data_src_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (dout_oe && !wait_act) |-> ($past(le_n) && $past(!ce_n)));
endmodule

bind burst_rd_seq brs_chk #(.DW(DW)) u_chk (
    .vclk     (vclk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .le_n     (le_n),
    .susp     (susp),
    .dout_oe  (dout_oe),
    .wait_act (wait_act),
    .dout     (dout)
);

// File: tb/burst_rd_seq_bench.sv
module burst_rd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          le_n = 1'b1;
    logic          susp = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [9:0]    cfg = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          wait_out;
    logic          tvclk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign tvclk = clk ^ cfg[8];

    function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
        logic [15:0] p;
        p = a * 16'h9E37;
        return p ^ 16'h5A5A;
    endfunction

    assign mem_rdata = mdata(mem_addr);

    burst_rd_seq #(.AW(AW), .DW(DW)) u_burst_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .le_n      (le_n),
        .susp      (susp),
        .addr_in   (addr_in),
        .cfg       (cfg),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .wait_out  (wait_out)
    );

    function automatic logic [9:0] mkcfg(input int bsel, input bit wrap, input int lat,
                                         input bit hold2, input bit fall, input bit pol);
        return {pol, fall, hold2, 3'(lat), wrap, 3'(bsel)};
    endfunction

    function automatic int exp_lat(input logic [9:0] c);
        return (c[6:4] < 2) ? 7 : int'(c[6:4]);
    endfunction

    function automatic int exp_len(input logic [9:0] c);
        if (c[2:0] == 0) return 4;
        if (c[2:0] == 1) return 8;
        if (c[2:0] == 2) return 16;
        return 0;
    endfunction

    function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a, input logic [9:0] c);
        int n;
        n = exp_len(c);
        if (n == 0 || !c[3]) return a + 1;
        return AW'((int'(a) / n) * n + ((int'(a) + 1) % n));
    endfunction

    function automatic logic wlvl(input bit active);
        return cfg[9] ? active : !active;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge tvclk);
        #2;
    endtask

    task automatic capture(input logic [AW-1:0] start, input logic [9:0] c);
        ce_n = 1'b1;
        cfg  = c;
        tick();
        tick();
        ce_n    = 1'b0;
        le_n    = 1'b0;
        addr_in = start;
        tick();
        le_n = 1'b1;
    endtask

    task automatic finish_abort();
        ce_n = 1'b1;
        tick();
        chk(dout_oe == 1'b0, "R10 oe after abort", 32'(dout_oe), 0);
        chk(wait_out == wlvl(0), "R10 wait after abort", 32'(wait_out), 32'(wlvl(0)));
    endtask

    // cycle-exact burst without suspend
    task automatic run_burst(input logic [AW-1:0] start, input logic [9:0] c, input int nobs);
        int L, n, H;
        logic [AW-1:0] a;
        bit crossed;
        capture(start, c);
        L = exp_lat(c);
        H = c[7] ? 2 : 1;
        n = (exp_len(c) == 0) ? nobs : exp_len(c);
        for (int i = 0; i < L; i++) begin
            chk(dout_oe == 1'b0, "R1 oe in latency", 32'(dout_oe), 0);
            chk(wait_out == wlvl(1), "R1 wait in latency", 32'(wait_out), 32'(wlvl(1)));
            tick();
        end
        a = start;
        crossed = 0;
        for (int w = 0; w < n; w++) begin
            if (w > 0) a = exp_next(a, c);
            if (exp_len(c) == 0 && w > 0 && a[3:0] == 0 && !crossed) begin
                crossed = 1;
                chk(wait_out == wlvl(1), "R5 gap wait", 32'(wait_out), 32'(wlvl(1)));
                chk(dout_oe == 1'b1, "R5 gap oe", 32'(dout_oe), 1);
                tick();
            end
            for (int h = 0; h < H; h++) begin
                chk(dout === mdata(a), "R3 R4 R6 word", 32'(dout), 32'(mdata(a)));
                chk(wait_out == wlvl(0), "R6 R7 wait in data", 32'(wait_out), 32'(wlvl(0)));
                chk(dout_oe == 1'b1, "R3 oe in data", 32'(dout_oe), 1);
                tick();
            end
        end
        if (exp_len(c) != 0) begin
            for (int k = 0; k < 2; k++) begin
                chk(wait_out == wlvl(1), "R8 wait at end", 32'(wait_out), 32'(wlvl(1)));
                chk(dout_oe == 1'b1, "R8 oe at end", 32'(dout_oe), 1);
                chk(dout === mdata(a), "R8 last word kept", 32'(dout), 32'(mdata(a)));
                tick();
            end
        end
        finish_abort();
    endtask

    // burst with random suspends; compares the collapsed word sequence
    task automatic run_susp(input logic [AW-1:0] start, input logic [9:0] c);
        logic [DW-1:0] got[$];
        logic [AW-1:0] a;
        int n;
        bit prev;
        susp = 1'b0;
        capture(start, c);
        n = (exp_len(c) == 0) ? 24 : exp_len(c);
        prev = 0;
        for (int cyc = 0; cyc < 320; cyc++) begin
            susp = (($urandom % 4) == 0);
            prev = susp;
            tick();
            if (prev) begin
                chk(dout_oe == 1'b0, "R9 oe while suspended", 32'(dout_oe), 0);
                chk(wait_out == wlvl(1), "R9 wait while suspended", 32'(wait_out), 32'(wlvl(1)));
            end
            if (dout_oe && wait_out == wlvl(0)) begin
                if (got.size() == 0 || got[$] !== dout) got.push_back(dout);
            end
            if (exp_len(c) == 0 && got.size() == n) break;
        end
        susp = 1'b0;
        chk(got.size() == n, "R9 word count", 32'(got.size()), 32'(n));
        a = start;
        for (int i = 0; i < n && i < got.size(); i++) begin
            if (i > 0) a = exp_next(a, c);
            chk(got[i] === mdata(a), "R9 resumed sequence", 32'(got[i]), 32'(mdata(a)));
        end
        finish_abort();
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        cfg = mkcfg(0, 0, 2, 0, 0, 1);
        #(CLK_PERIOD * 3);
        #2;
        rst_n = 1'b1;
        tick();
        // R11
        chk(dout_oe == 1'b0, "R11 oe after reset", 32'(dout_oe), 0);
        chk(wait_out == wlvl(0), "R11 wait after reset", 32'(wait_out), 32'(wlvl(0)));
        chk(dout == '0, "R11 dout after reset", 32'(dout), 0);

        // R4 wrap inside a 4-word block from an unaligned start
        run_burst(16'h0006, mkcfg(0, 1, 2, 0, 0, 1), 0);
        // R4 no wrap across an 8-word block edge
        run_burst(16'h0006, mkcfg(1, 0, 5, 0, 0, 1), 0);
        // R6 two-cycle hold, 16-word wrap
        run_burst(16'h0023, mkcfg(2, 1, 3, 1, 0, 1), 0);
        // R5 R2 unbounded burst on the falling edge
        run_burst(16'h000D, mkcfg(7, 1, 7, 0, 1, 1), 22);
        // R1 latency code 0 behaves as 7
        run_burst(16'h0040, mkcfg(0, 0, 0, 0, 0, 1), 0);
        // R7 active-low wait
        run_burst(16'h0011, mkcfg(1, 1, 4, 1, 0, 0), 0);
        // R5 start on a multiple of 16
        run_burst(16'h0020, mkcfg(4, 0, 2, 1, 0, 1), 36);

        // R2 no capture on the rising edge when the falling edge is selected
        ce_n = 1'b1;
        cfg  = mkcfg(0, 0, 3, 0, 1, 1);
        tick();
        tick();
        ce_n = 1'b0;
        le_n = 1'b0;
        addr_in = 16'h0003;
        @(posedge clk);
        #2;
        chk(wait_out == wlvl(0), "R2 no capture at rising edge", 32'(wait_out), 32'(wlvl(0)));
        @(negedge clk);
        #2;
        le_n = 1'b1;
        chk(wait_out == wlvl(1), "R2 capture at falling edge", 32'(wait_out), 32'(wlvl(1)));
        finish_abort();

        // R10 abort in mid data
        capture(16'h0100, mkcfg(2, 0, 2, 0, 0, 1));
        for (int i = 0; i < 5; i++) tick();
        chk(dout_oe == 1'b1, "R10 burst running", 32'(dout_oe), 1);
        finish_abort();
        tick();
        chk(dout_oe == 1'b0, "R10 stays idle", 32'(dout_oe), 0);

        // R9 directed suspend inside an unbounded burst near the 16 boundary
        run_susp(16'h000E, mkcfg(3, 0, 2, 1, 0, 1));

        // random bursts
        for (int r = 0; r < 40; r++) begin
            logic [9:0] c;
            c = mkcfg(int'($urandom % 8), 1'($urandom), int'($urandom % 8),
                      1'($urandom), 1'($urandom), 1'($urandom));
            run_burst(AW'($urandom % 512), c, 17 + int'($urandom % 24));
        end
        for (int r = 0; r < 12; r++) begin
            logic [9:0] c;
            c = mkcfg(int'($urandom % 8), 1'($urandom), int'($urandom % 8),
                      1'($urandom), 1'($urandom), 1'($urandom));
            run_susp(AW'($urandom % 512), c);
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule